// File: doc/BRIEF.md
# I2C Host Controller

This block is a byte-oriented I2C bus master that a host controls through five 8-bit registers. The host loads a 16-bit clock divider, turns the core on, puts a byte in the data register and writes a single command byte. That command byte can ask for a START condition, one byte transmitted or received, the acknowledge level to drive after a received byte, and a closing STOP. The block runs the requested parts in that fixed order on open-drain SCL and SDA, then raises a completion flag. The host clears the flag by setting a bit in a later command.

The sequencer splits every SCL bit into five phases. A phase lasts `prescale + 1` clock cycles. The block watches the bus lines through a two-flop synchroniser. From them it tracks whether the bus is busy, and it detects when another master has won arbitration. When it loses, it lets go of both lines and stops the transfer.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, the registers read as follows: prescale low 0xFF, prescale high 0xFF, control 0x00, data 0x00, status 0x00. Both line drivers are released and `irq` is low.
- R2: Register map: address 0 is prescale bits 7:0 and address 1 is prescale bits 15:8. These can be written only while control bit 7 (core enable) is 0. A write while the core is enabled leaves the value, and the SCL timing, unchanged.
- R3: A command written while the core is disabled is ignored. Transfer-in-progress stays low and no line is driven.
- R4: Command bit 7 produces a START. Bit 4 transmits the byte last written to address 3, MSB first. A write command without bit 7 sends the byte with no START in front of it.
- R5: With the core enabled, one SCL period is exactly 5 × (prescale + 1) clock cycles.
- R6: Reading address 4 returns the status byte: bit 7 is the sampled acknowledge level, bit 6 bus busy, bit 5 arbitration lost, bit 1 transfer in progress and bit 0 the interrupt flag. Bus busy sets on a START seen on the lines and clears on a STOP seen on the lines.
- R7: Transfer-in-progress is high from the cycle after a command with any of bits 7:4 set is accepted until that command has finished.
- R8: The interrupt flag sets when a command completes and also when arbitration is lost. A command write with bit 0 set clears it. `irq` is the flag ANDed with control bit 6.
- R9: The SDA level sampled during the ninth clock of a byte is stored in status bit 7. A 1 there means the slave did not acknowledge.
- R10: Command bit 5 receives 8 bits, MSB first, into the register read at address 3. After the byte the block drives ACK (SDA low) when command bit 3 is 0, and NACK (SDA released) when it is 1.
- R11: Command bit 6 ends the command with a STOP, which is SDA rising while SCL is high. Both lines are then released and bus busy clears.
- R12: The block loses arbitration in two cases. One is when it releases SDA for a 1 and samples it low. The other is when a STOP it did not request appears while a command is active. On a loss it releases both lines at once, sets status bit 5, drops transfer-in-progress and sets the interrupt flag. The next accepted command clears bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | When 1, pull SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low |

## Verification
A wrong phase count or a bad divider reload shows up on the very next SCL edge as a period other than 5 × (prescale + 1). A wrong bit counter or a wrong shift order shows up at the ninth clock of a byte, as a wrong byte on the wire or in the data register. A sequencer that stays in the wrong state shows up within one byte time in one of three ways: the lines are not released, transfer-in-progress stays stuck, or the interrupt flag never appears. A missed arbitration check shows up on the very next sample point, because the lines keep being driven and status bit 5 stays low.

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl #(
  parameter int          ADDR_W    = 3,
  parameter logic [15:0] PRE_RESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe
);
  localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(4);
  localparam logic [2:0]        PH_LAST = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ACK, S_STOP} seq_t;

  logic [15:0] prescale, pcnt;
  logic        en, ien;
  logic [7:0]  txr, rxr, sr;
  seq_t        state;
  logic [2:0]  ph, bitn;
  logic        op_rd, op_wr, op_stop, op_nack;
  logic        samp, rxack, busy, al, iflag;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_p, sda_p;
  logic        scl_w, sda_w;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire start_det = scl_s && scl_p && sda_p && !sda_s;
  wire stop_det  = scl_s && scl_p && !sda_p && sda_s;
  wire tip       = (state != S_IDLE);
  wire wr_cmd    = reg_we && (reg_addr == A_CMD);
  wire go        = wr_cmd && en && !tip && (|reg_wdata[7:4]);
  wire tick      = tip && (pcnt == 16'd0);
  wire bit_end   = tick && (ph == PH_LAST);
  wire smp       = tick && (ph == 3'd2);
  wire want_hi   = (state == S_DATA && op_wr && sr[7]) ||
                   (state == S_ACK && op_rd && op_nack);
  wire al_hit    = (tick && ph == 3'd1 && state == S_START && !sda_s) ||
                   (smp && want_hi && !sda_s) ||
                   (stop_det && tip && state != S_STOP);
  wire fin       = bit_end && ((state == S_STOP) ||
                   (state == S_ACK && !op_stop) ||
                   (state == S_START && !op_rd && !op_wr && !op_stop));

  assign irq = iflag & ien;

  always_comb begin
    case (reg_addr)
      A_PLO:   reg_rdata = prescale[7:0];
      A_PHI:   reg_rdata = prescale[15:8];
      A_CTL:   reg_rdata = {en, ien, 6'b0};
      A_DAT:   reg_rdata = rxr;
      A_CMD:   reg_rdata = {rxack, busy, al, 3'b0, tip, iflag};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    scl_w = scl_oe;
    sda_w = sda_oe;
    case (state)
      S_START: begin
        sda_w = (ph >= 3'd2);
        scl_w = (ph == 3'd0) ? scl_oe : (ph == PH_LAST);
      end
      S_DATA: begin
        sda_w = op_wr & ~sr[7];
        scl_w = (ph == 3'd0) || (ph == PH_LAST);
      end
      S_ACK: begin
        sda_w = op_rd & ~op_nack;
        scl_w = (ph == 3'd0) || (ph == PH_LAST);
      end
      S_STOP: begin
        sda_w = (ph <= 3'd2);
        scl_w = (ph == 3'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale <= PRE_RESET;
      en       <= 1'b0;
      ien      <= 1'b0;
      txr      <= '0;
      pcnt     <= '0;
      busy     <= 1'b0;
      al       <= 1'b0;
      iflag    <= 1'b0;
      samp     <= 1'b1;
    end else begin
      if (reg_we && !en && reg_addr == A_PLO) prescale[7:0]  <= reg_wdata;
      if (reg_we && !en && reg_addr == A_PHI) prescale[15:8] <= reg_wdata;
      if (reg_we && reg_addr == A_CTL) begin
        en  <= reg_wdata[7];
        ien <= reg_wdata[6];
      end
      if (reg_we && reg_addr == A_DAT) txr <= reg_wdata;
      pcnt <= (!tip || tick) ? prescale : pcnt - 16'd1;
      if (smp) samp <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
      if (al_hit)  al <= 1'b1;
      else if (go) al <= 1'b0;
      if (fin || al_hit)                iflag <= 1'b1;
      else if (wr_cmd && reg_wdata[0])  iflag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph      <= '0;
      bitn    <= '0;
      sr      <= '0;
      rxr     <= '0;
      rxack   <= 1'b0;
      op_rd   <= 1'b0;
      op_wr   <= 1'b0;
      op_stop <= 1'b0;
      op_nack <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      if (!en || al_hit) begin
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else if (tip) begin
        scl_oe <= scl_w;
        sda_oe <= sda_w;
      end
      if (!en || al_hit) begin
        state <= S_IDLE;
        ph    <= '0;
      end else if (go) begin
        ph      <= '0;
        bitn    <= '0;
        sr      <= txr;
        op_wr   <= reg_wdata[4];
        op_rd   <= reg_wdata[5] & ~reg_wdata[4];
        op_stop <= reg_wdata[6];
        op_nack <= reg_wdata[3];
        state   <= reg_wdata[7] ? S_START :
                   (reg_wdata[5] | reg_wdata[4]) ? S_DATA : S_STOP;
      end else if (tick) begin
        ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
        if (ph == PH_LAST) begin
          case (state)
            S_START: state <= (op_rd | op_wr) ? S_DATA : (op_stop ? S_STOP : S_IDLE);
            S_DATA: begin
              sr   <= {sr[6:0], samp};
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) state <= S_ACK;
            end
            S_ACK: begin
              rxack <= samp;
              if (op_rd) rxr <= sr;
              state <= op_stop ? S_STOP : S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R2
  prescale_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && en && (reg_addr == A_PLO || reg_addr == A_PHI)) |=> $stable(prescale));

  // R3
  disabled_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !en) |=> (state == S_IDLE && !scl_oe && !sda_oe));

  // R7
  tip_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && en && state == S_IDLE && (|reg_wdata[7:4])) |=> (reg_rdata[1] || reg_addr != A_CMD) && state != S_IDLE);

  // R8
  iack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[0] && state == S_IDLE) |=> !iflag && !irq);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && bit_end) |=> (!scl_oe && !sda_oe && state == S_IDLE));

  // R12
  al_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (!scl_oe && !sda_oe && state == S_IDLE && iflag));

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale != 16'd0) |=> !tick);
endmodule

// File: tb/tb_i2c_host_ctrl.sv
module tb_i2c_host_ctrl;
  localparam int P = 4;
  localparam int PERIOD = 5 * (P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, scl_oe, sda_oe;
  logic       s_low;
  wire        scl = ~scl_oe;
  wire        sda = ~(sda_oe | s_low);

  i2c_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq), .scl_i(scl), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // slave / other-master model on the wires
  logic sp_scl = 1'b1, sp_sda = 1'b1, act = 1'b0;
  int   cnt = 0, dcnt = 0, per = 0, tsince = 0;
  logic s_rd = 1'b0, s_ack = 1'b1, jam = 1'b0;
  int   jam_idx = 0;
  logic [7:0] s_tx = '0, s_sh = '0, rx_b = '0;
  logic m_ack = 1'b0, rx_v = 1'b0;

  always_comb s_low = act && ((jam && !s_rd && dcnt == jam_idx) ||
                              (!s_rd && s_ack && dcnt == 8) ||
                              (s_rd && dcnt < 8 && !s_tx[3'(7 - dcnt)]));

  always @(negedge clk) begin
    rx_v   <= 1'b0;
    tsince <= tsince + 1;
    sp_scl <= scl;
    sp_sda <= sda;
    if (sp_scl && scl && sp_sda && !sda) begin
      cnt <= 0; dcnt <= 0; act <= 1'b0;
    end else if (sp_scl && scl && !sp_sda && sda) begin
      cnt <= 0; dcnt <= 0; act <= 1'b0;
    end else if (!sp_scl && scl) begin
      per    <= tsince;
      tsince <= 1;
      if (cnt < 8) begin
        s_sh <= {s_sh[6:0], sda};
        if (cnt == 7 && !s_rd) begin
          rx_v <= 1'b1;
          rx_b <= {s_sh[6:0], sda};
        end
      end else if (s_rd) m_ack <= sda;
      cnt <= cnt + 1;
    end else if (sp_scl && !scl) begin
      act <= 1'b1;
      if (cnt >= 9) begin cnt <= 0; dcnt <= 0; end
      else dcnt <= cnt;
    end
  end

  // scoreboard monitor: bytes seen on the wire (R4)
  always @(negedge clk) begin
    if (rx_v) begin
      if (exp_q.size() == 0) check("R4 unexpected wire byte", {24'h0, rx_b}, 32'hFFFF_FFFF);
      else check("R4 wire byte", {24'h0, rx_b}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] cmd);
    exp_q.push_back(b);
    wr(3'd3, b);
    wr(3'd4, cmd);
  endtask

  task automatic wait_flag();
    logic [7:0] s;
    for (int t = 0; t < 4000; t++) begin
      rd(3'd4, s);
      if (s[0]) return;
    end
    check("R8 completion flag timeout", 0, 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); check("R1 prescale lo", v, 8'hFF);
    rd(3'd1, v); check("R1 prescale hi", v, 8'hFF);
    rd(3'd2, v); check("R1 control", v, 8'h00);
    rd(3'd3, v); check("R1 data", v, 8'h00);
    rd(3'd4, v); check("R1 status", v, 8'h00);
    check("R1 lines/irq", {irq, scl_oe, sda_oe}, 3'b000);

    wr(3'd0, 8'(P)); wr(3'd1, 8'h00);
    rd(3'd0, v); check("R2 prescale lo write", v, 8'(P));
    rd(3'd1, v); check("R2 prescale hi write", v, 8'h00);

    wr(3'd3, 8'h54); wr(3'd4, 8'h91);
    repeat (60) @(negedge clk);
    rd(3'd4, v); check("R3 command ignored while disabled", v, 8'h00);
    check("R3 lines idle", {scl_oe, sda_oe}, 2'b00);

    wr(3'd2, 8'hC0);
    wr(3'd0, 8'h20);
    rd(3'd0, v); check("R2 prescale locked while enabled", v, 8'(P));

    s_rd = 1'b0; s_ack = 1'b1;
    send(8'h54, 8'h91);
    rd(3'd4, v); check("R7 tip set after accept", v[1], 1'b1);
    wait_flag();
    rd(3'd4, v); check("R6 R9 status after addressed write", v, 8'h41);
    check("R8 irq with enable", irq, 1'b1);
    check("R5 SCL period", per, PERIOD);

    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R8 IACK clears flag", v, 8'h40);
    check("R8 irq cleared", irq, 1'b0);

    send(8'hA5, 8'h11);
    wait_flag();
    rd(3'd4, v); check("R4 write without START status", v, 8'h41);
    check("R4 bus held after byte", scl_oe, 1'b1);
    check("R2 SCL period unchanged", per, PERIOD);

    send(8'h55, 8'h11);
    wait_flag();
    s_rd = 1'b1; s_tx = 8'h3C;
    wr(3'd4, 8'h21);
    wait_flag();
    rd(3'd3, v); check("R10 received byte ACK", v, 8'h3C);
    check("R10 master drove ACK", m_ack, 1'b0);

    s_tx = 8'hC3;
    wr(3'd4, 8'h69);
    wait_flag();
    rd(3'd3, v); check("R10 received byte NACK", v, 8'hC3);
    check("R10 master drove NACK", m_ack, 1'b1);
    repeat (4) @(negedge clk);
    rd(3'd4, v); check("R11 status after read with STOP", v, 8'h81);
    check("R11 lines released", {scl_oe, sda_oe}, 2'b00);

    s_rd = 1'b0; s_ack = 1'b0;
    send(8'h54, 8'h91);
    wait_flag();
    rd(3'd4, v); check("R9 slave NACK seen", v, 8'hC1);
    wr(3'd4, 8'h41);
    wait_flag();
    repeat (4) @(negedge clk);
    rd(3'd4, v); check("R11 STOP-only command", v, 8'h81);

    wr(3'd2, 8'h80);
    check("R8 irq masked", irq, 1'b0);
    wr(3'd2, 8'hC0);
    check("R8 irq unmasked", irq, 1'b1);
    wr(3'd4, 8'h01);

    s_ack = 1'b1; jam = 1'b1; jam_idx = 2;
    wr(3'd3, 8'hFF); wr(3'd4, 8'h91);
    wait_flag();
    rd(3'd4, v); check("R12 lost arbitration status", v & 8'h23, 8'h21);
    check("R12 lines released", {scl_oe, sda_oe}, 2'b00);
    jam = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd4, v); check("R6 busy cleared by STOP on lines", v[6], 1'b0);

    send(8'h54, 8'h91);
    wait_flag();
    rd(3'd4, v); check("R12 lost flag cleared by next command", v, 8'h41);
    wr(3'd4, 8'h41);
    wait_flag();
    repeat (4) @(negedge clk);
    rd(3'd4, v); check("R11 final STOP", v, 8'h01);
    check("R4 all expected wire bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule